// File: doc/BRIEF.md
# Write Command Clock-Count Guard

This block sits beside the command decoder of a three-wire-plus-select serial memory port. It guards the four commands that change the array: single-word write, single-word erase, fill-all and clear-all. From the serial clock edge that carries the start bit until the select line drops, it counts every serial clock rising edge. When select falls, it compares that count with the exact length that the decoded command needs at the configured address width. If the count is off in either direction, the write controller is told to drop the command. A noise pulse or a double-counted edge therefore cannot turn a harmless command into a memory change. One example is a disable command that gains a clock and decodes as an erase of word 0.

The guard passes read, write-enable and write-disable commands without checking them. A read may stream for as many clocks as the host likes. The count saturates rather than wrapping, so no clock burst can fold back onto a legal length. The count is cleared whenever select is low, so each framed transaction is judged on its own clocks.

The host-side decoder supplies four signals: a one-cycle strobe per serial clock rising edge, a level that is high from the start-bit edge onward, the decoded command code and the address-width selection. The guard returns a one-cycle verdict one clock after it sees select low.

Top module: `wrcmd_len_guard`

## Requirements
- R1: After reset, `done_o`, `accept_o` and `cancel_o` are all low, and they stay low until a framed transaction ends.
- R2: A serial edge is counted only while `sel_i` is high and `start_seen_i` is high. The start-bit edge is count 1. Leading edges with `start_seen_i` low (dummy clocks) are not counted.
- R3: With `wide_addr_i`=0, write (code 2) and fill-all (code 4) are accepted only when exactly 25 edges were counted.
- R4: With `wide_addr_i`=0, erase (code 3) and clear-all (code 5) are accepted only when exactly 9 edges were counted.
- R5: With `wide_addr_i`=1, write and fill-all need exactly 27 edges, and erase and clear-all need exactly 11.
- R6: A modifying command whose count is higher or lower than its required length is cancelled. This covers a disable command that picks up one noise edge and decodes as erase.
- R7: Read (code 1), write-enable (code 6) and write-disable (code 7) are always accepted, whatever the count.
- R8: The verdict is a one-cycle `done_o` pulse one clock after the first cycle with `sel_i` low following a high period. Exactly one of `accept_o`/`cancel_o` is high with it, and neither is high without it. Code 0 (no command decoded) produces no verdict.
- R9: The edge count saturates at its maximum. A burst longer than the counter range still cancels a modifying command and never aliases to a legal length.
- R10: The count returns to zero while `sel_i` is low, so back-to-back transactions are judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Synchronised select level; high frames a transaction |
| sk_rise_i | input | 1 | One-cycle strobe per serial clock rising edge |
| start_seen_i | input | 1 | High from the start-bit edge until select drops |
| cmd_i | input | 3 | Decoded command: 0 none, 1 read, 2 write, 3 erase, 4 fill-all, 5 clear-all, 6 enable, 7 disable |
| wide_addr_i | input | 1 | 0: 6-bit address layout, 1: 8-bit address layout |
| done_o | output | 1 | Verdict strobe |
| accept_o | output | 1 | Command may proceed (valid with `done_o`) |
| cancel_o | output | 1 | Command must be dropped (valid with `done_o`) |

## Verification
The bench builds the block with its default parameters: a 2-bit opcode, 16-bit data, and 6- and 8-bit address layouts. These give required lengths of 9/25 and 11/27, and a 5-bit counter that saturates at 31. Because the counter is that small, a 57-edge write burst (25 plus 32) and a 43-edge erase burst (11 plus 32) can be simulated, and either one would alias onto a legal length if the counter wrapped. The reference model counts with an unbounded integer, so a saturation fault or a wrap fault shows up as a verdict mismatch.

// File: rtl/clkguard_pkg.sv
package clkguard_pkg;

   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_READ  = 3'd1,
      CMD_WRITE = 3'd2,
      CMD_ERASE = 3'd3,
      CMD_WRALL = 3'd4,
      CMD_ERALL = 3'd5,
      CMD_WREN  = 3'd6,
      CMD_WRDIS = 3'd7
   } cmd_e;

   // commands that alter the array and must be length-checked
   function automatic logic is_modifying(cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_ERASE) ||
             (c == CMD_WRALL) || (c == CMD_ERALL);
   endfunction

   // commands that carry a data word after the address
   function automatic logic carries_data(cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_WRALL);
   endfunction

endpackage

// File: rtl/clkguard_ticker.sv
module clkguard_ticker #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] ticks
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ticks <= '0;
      end else if (clr) begin
         ticks <= '0;
      end else if (inc && (ticks != TOP)) begin
         ticks <= ticks + CNT_W'(1);
      end
   end
endmodule

// File: rtl/clkguard_lenrom.sv
module clkguard_lenrom
   import clkguard_pkg::*;
#(
   parameter int OP_W        = 2,
   parameter int DATA_W      = 16,
   parameter int ADDR_NARROW = 6,
   parameter int ADDR_WIDE   = 8,
   parameter int CNT_W       = 5
) (
   input  cmd_e             cmd,
   input  logic             wide,
   output logic             need_chk,
   output logic [CNT_W-1:0] need_len
);
   localparam int N_CFG = 2;

   logic [CNT_W-1:0] short_len [N_CFG];
   logic [CNT_W-1:0] long_len  [N_CFG];

   // one length pair per address layout: start + opcode + address [+ data]
   for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
      localparam int AW      = (g == 0) ? ADDR_NARROW : ADDR_WIDE;
      localparam int LEN_CMD = 1 + OP_W + AW;
      localparam int LEN_DAT = LEN_CMD + DATA_W;
      assign short_len[g] = CNT_W'(LEN_CMD);
      assign long_len[g]  = CNT_W'(LEN_DAT);
   end

   always_comb begin
      need_chk = is_modifying(cmd);
      need_len = carries_data(cmd) ? long_len[wide] : short_len[wide];
   end
endmodule

// File: rtl/clkguard_judge.sv
module clkguard_judge #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             cmd_valid,
   input  logic             need_chk,
   input  logic [CNT_W-1:0] ticks,
   input  logic [CNT_W-1:0] need_len,
   output logic             done_o,
   output logic             accept_o,
   output logic             cancel_o
);
   logic sel_q;
   logic closing;
   logic len_ok;

   assign closing = sel_q & ~sel_i & cmd_valid;
   assign len_ok  = (ticks == need_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= 1'b0;
         done_o   <= 1'b0;
         accept_o <= 1'b0;
         cancel_o <= 1'b0;
      end else begin
         sel_q    <= sel_i;
         done_o   <= closing;
         accept_o <= closing & (~need_chk | len_ok);
         cancel_o <= closing & need_chk & ~len_ok;
      end
   end
endmodule

// File: rtl/wrcmd_len_guard.sv
module wrcmd_len_guard
   import clkguard_pkg::*;
#(
   parameter int OP_W        = 2,
   parameter int DATA_W      = 16,
   parameter int ADDR_NARROW = 6,
   parameter int ADDR_WIDE   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_i,
   input  logic       sk_rise_i,
   input  logic       start_seen_i,
   input  logic [2:0] cmd_i,
   input  logic       wide_addr_i,
   output logic       done_o,
   output logic       accept_o,
   output logic       cancel_o
);
   localparam int LEN_MAX = 1 + OP_W + ADDR_WIDE + DATA_W;
   localparam int CNT_W   = $clog2(LEN_MAX + 1);

   if (OP_W < 1)              $error("OP_W must be at least 1");
   if (DATA_W < 1)            $error("DATA_W must be at least 1");
   if (ADDR_NARROW < 1)       $error("ADDR_NARROW must be at least 1");
   if (ADDR_WIDE < ADDR_NARROW) $error("ADDR_WIDE must not be below ADDR_NARROW");

   cmd_e             cmd_t;
   logic             cmd_valid;
   logic             need_chk;
   logic [CNT_W-1:0] need_len;
   logic [CNT_W-1:0] ticks;
   logic             tick_inc;

   assign cmd_t     = cmd_e'(cmd_i);
   assign cmd_valid = (cmd_t != CMD_NONE);
   assign tick_inc  = sel_i & sk_rise_i & start_seen_i;

   clkguard_ticker #(.CNT_W(CNT_W)) u_ticker (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~sel_i),
      .inc   (tick_inc),
      .ticks (ticks)
   );

   clkguard_lenrom #(
      .OP_W        (OP_W),
      .DATA_W      (DATA_W),
      .ADDR_NARROW (ADDR_NARROW),
      .ADDR_WIDE   (ADDR_WIDE),
      .CNT_W       (CNT_W)
   ) u_lenrom (
      .cmd      (cmd_t),
      .wide     (wide_addr_i),
      .need_chk (need_chk),
      .need_len (need_len)
   );

   clkguard_judge #(.CNT_W(CNT_W)) u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (sel_i),
      .cmd_valid (cmd_valid),
      .need_chk  (need_chk),
      .ticks     (ticks),
      .need_len  (need_len),
      .done_o    (done_o),
      .accept_o  (accept_o),
      .cancel_o  (cancel_o)
   );
endmodule

// File: rtl/wrcmd_len_guard_chk.sv
module wrcmd_len_guard_chk
   import clkguard_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_i,
   input logic             sk_rise_i,
   input logic             start_seen_i,
   input logic [2:0]       cmd_i,
   input logic             done_o,
   input logic             accept_o,
   input logic             cancel_o,
   input logic [CNT_W-1:0] ticks
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   // R8
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept_o && cancel_o));

   // R8
   verdict_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o || cancel_o) |-> done_o);

   // R8
   verdict_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(!sel_i));

   // R7
   passthru_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ($past(cmd_i) == 3'd1 || $past(cmd_i) == 3'd6 || $past(cmd_i) == 3'd7))
      |-> accept_o);

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !(sk_rise_i && start_seen_i)) |=> $stable(ticks));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && sk_rise_i && start_seen_i && ticks == TOP) |=> (ticks == TOP));

   // R10
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> (ticks == '0));
endmodule

bind wrcmd_len_guard wrcmd_len_guard_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sel_i        (sel_i),
   .sk_rise_i    (sk_rise_i),
   .start_seen_i (start_seen_i),
   .cmd_i        (cmd_i),
   .done_o       (done_o),
   .accept_o     (accept_o),
   .cancel_o     (cancel_o),
   .ticks        (ticks)
);

// File: tb/wrcmd_len_guard_test.sv
`timescale 1ns/1ps
module wrcmd_len_guard_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       sk = 1'b0;
   logic       st = 1'b0;
   logic [2:0] cmd = 3'd0;
   logic       wide = 1'b0;
   logic       done_o, accept_o, cancel_o;

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    ended = 1'b0;

   // reference model state
   int m_cnt = 0;
   bit m_selq = 0;
   bit e_done = 0, e_acc = 0, e_can = 0;

   always #2 clk = ~clk;

   wrcmd_len_guard uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_i        (sel),
      .sk_rise_i    (sk),
      .start_seen_i (st),
      .cmd_i        (cmd),
      .wide_addr_i  (wide),
      .done_o       (done_o),
      .accept_o     (accept_o),
      .cancel_o     (cancel_o)
   );

   function automatic int need(input logic [2:0] c, input logic w);
      if (c == 3'd2 || c == 3'd4) return w ? 27 : 25;
      return w ? 11 : 9;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_selq = 0; e_done = 0; e_acc = 0; e_can = 0;
      end else begin
         e_done = 0; e_acc = 0; e_can = 0;
         if (m_selq && !sel && cmd != 3'd0) begin
            e_done = 1;
            if (cmd >= 3'd2 && cmd <= 3'd5) begin
               e_acc = (m_cnt == need(cmd, wide));
               e_can = !e_acc;
            end else begin
               e_acc = 1;
            end
         end
         if (!sel) m_cnt = 0;
         else if (sk && st) m_cnt = m_cnt + 1;
         m_selq = sel;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !ended) begin
         n_chk++;
         if ({done_o, accept_o, cancel_o} !== {e_done, e_acc, e_can}) begin
            n_bad++;
            $display("FAIL %s: done/acc/can actual %b%b%b expected %b%b%b",
                     cur_req, done_o, accept_o, cancel_o, e_done, e_acc, e_can);
         end
      end
   end

   task automatic xact(input logic [2:0] c, input logic w, input int dummies,
                       input int n, input string tag);
      cur_req = tag;
      @(negedge clk); sel = 1; cmd = c; wide = w;
      for (int i = 0; i < dummies; i++) begin
         @(negedge clk); sk = 1;
         @(negedge clk); sk = 0;
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sk = 1; st = 1;
         @(negedge clk); sk = 0;
      end
      @(negedge clk); sel = 0; st = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 explicit reset-state check
      n_chk++;
      if ({done_o, accept_o, cancel_o} !== 3'b000) begin
         n_bad++;
         $display("FAIL R1: actual %b%b%b expected 000", done_o, accept_o, cancel_o);
      end
      xact(3'd2, 0, 0, 25, "R3");
      xact(3'd4, 0, 0, 25, "R3");
      xact(3'd2, 0, 0, 24, "R3");
      xact(3'd4, 0, 0, 26, "R3");
      xact(3'd3, 0, 0, 9,  "R4");
      xact(3'd5, 0, 0, 9,  "R4");
      xact(3'd3, 0, 0, 8,  "R4");
      xact(3'd2, 1, 0, 27, "R5");
      xact(3'd4, 1, 0, 27, "R5");
      xact(3'd3, 1, 0, 11, "R5");
      xact(3'd5, 1, 0, 11, "R5");
      xact(3'd2, 1, 0, 25, "R5");
      xact(3'd3, 1, 0, 12, "R6");
      xact(3'd3, 0, 0, 10, "R6");
      xact(3'd5, 1, 0, 10, "R6");
      xact(3'd1, 0, 0, 40, "R7");
      xact(3'd6, 1, 0, 11, "R7");
      xact(3'd7, 0, 0, 12, "R7");
      xact(3'd2, 0, 3, 25, "R2");
      xact(3'd3, 1, 5, 11, "R2");
      xact(3'd0, 0, 6, 0,  "R8");
      xact(3'd2, 0, 0, 57, "R9");
      xact(3'd3, 1, 0, 43, "R9");
      xact(3'd3, 0, 0, 9,  "R10");
      xact(3'd2, 0, 0, 25, "R10");
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule